// File: doc/BRIEF.md
# Card Status-Change Register Unit

This block holds two byte-wide registers of a removable storage card's attribute space. A configuration/status byte holds the host's enable for the status-change signal, an 8-bit I/O preference, a power-down request and a read-only interrupt-pending flag. A pin-status byte shows the live ready and write-protect lines together with a sticky change flag for each of them. The host reaches both through a simple byte port. A write strobe stores data on the clock edge, and read data follows the address combinationally.

The live ready and write-protect inputs pass through a two-flop synchroniser. An edge on the synchronised value in either direction sets the matching sticky bit. The OR of the two sticky bits is the summary flag `Changed`. When the card is in I/O mode and the host has enabled the signal, that flag drives the active-low status-change output. A change of the power-down request moves a four-state power FSM into a busy state, where it waits for the power sequencer's acknowledge. The states are PWR_ACTIVE, PWR_ENTER_DOWN, PWR_DOWN and PWR_EXIT_DOWN. The transitions are:

- A write of 1 moves PWR_ACTIVE or PWR_EXIT_DOWN to PWR_ENTER_DOWN.
- A write of 0 moves PWR_DOWN or PWR_ENTER_DOWN to PWR_EXIT_DOWN.
- An acknowledge with no such write moves PWR_ENTER_DOWN to PWR_DOWN and PWR_EXIT_DOWN to PWR_ACTIVE.

Top module: `card_stchg_regs`

## Requirements
- R1: The configuration/status byte is at offset 0x202 and the pin-status byte at 0x204. A read of any other offset returns 0x00, and a write there has no effect.
- R2: The configuration/status byte reads as {Changed, SigEn, IoByte, 0, 0, PwrDn, IntPend, 0} from bit 7 down to bit 0. A write stores bit 6 into SigEn, bit 5 into IoByte and bit 2 into PwrDn, and ignores all other bits.
- R3: IntPend (bit 1 of 0x202) equals `irq_req` AND NOT `irq_dis` in every mode.
- R4: IoByte is stored and read back but changes no other output.
- R5: The pin-status byte reads as {0, 0, RdyChg, WpChg, 1, 1, live ready, live protect} from bit 7 down to bit 0. The live bits are the raw inputs delayed by two clock edges.
- R6: RdyChg sets on the third clock edge after `ready_raw` changes, in either direction. WpChg behaves the same way for `wprot_raw`.
- R7: A write to 0x204 stores bit 5 into RdyChg and bit 4 into WpChg, and ignores bits 1:0. When an edge and a host write hit the same sticky bit in one cycle, the bit ends up set.
- R8: Changed is 1 exactly when RdyChg or WpChg is 1.
- R9: `stschg_n` is 0 exactly when `io_mode`, Changed and SigEn are all 1. Otherwise, including whenever `io_mode` is 0, it is 1.
- R10: A write to 0x202 whose bit 2 differs from the stored PwrDn raises `busy` after that edge. `busy` then stays 1 until an edge where `pwr_done` is 1 and no further change of PwrDn is written. A write that keeps PwrDn unchanged does not raise `busy`.
- R11: After reset, all sticky bits, SigEn, IoByte and PwrDn are 0, `busy` is 0 and the FSM is in PWR_ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Attribute byte offset |
| host_wr | input | 1 | Write strobe, sampled on clock edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| ready_raw | input | 1 | Asynchronous live ready line |
| wprot_raw | input | 1 | Asynchronous live write-protect line |
| irq_req | input | 1 | Pending internal interrupt request |
| irq_dis | input | 1 | Interrupt disable from device control |
| io_mode | input | 1 | Card configured for I/O interface |
| pwr_done | input | 1 | Requested power state reached |
| stschg_n | output | 1 | Active-low status-change output |
| busy | output | 1 | Busy while a power transition is pending |

## Verification
The hardest case to reach from the ports is a line edge that lands on the same cycle as a host write clearing that sticky bit. The edge appears two edges after the raw line moves, so the write has to be timed to that cycle. A directed sequence toggles `ready_raw` and then writes zero to the pin-status byte exactly two cycles later. Random traffic then mixes line toggles, writes, acknowledges and mode changes, while a cycle-accurate bench model predicts every read byte, `stschg_n` and `busy`.

// File: rtl/card_stchg_pkg.sv
package card_stchg_pkg;
    typedef enum logic [1:0] {
        PWR_ACTIVE     = 2'd0,
        PWR_ENTER_DOWN = 2'd1,
        PWR_DOWN       = 2'd2,
        PWR_EXIT_DOWN  = 2'd3
    } pwr_state_t;

    // index of each tracked line inside the line vector
    localparam int LINE_RDY = 1;
    localparam int LINE_WP  = 0;
    localparam int NUM_LINES = 2;

    // configuration/status byte bit positions
    localparam int CFG_CHG_BIT = 7;
    localparam int CFG_SIG_BIT = 6;
    localparam int CFG_IO8_BIT = 5;
    localparam int CFG_PWR_BIT = 2;
    localparam int CFG_INT_BIT = 1;

    // pin-status byte bit positions
    localparam int PIN_RCHG_BIT = 5;
    localparam int PIN_WCHG_BIT = 4;
endpackage

// File: rtl/card_line_sync.sv
module card_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/card_change_track.sv
module card_change_track #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] live,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_val,
    output logic [WIDTH-1:0] sticky
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= live;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic chg_q;
        logic edge_seen;

        assign edge_seen = live[i] ^ prev_q[i];

        // edge wins over a host write in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         chg_q <= 1'b0;
            else if (edge_seen) chg_q <= 1'b1;
            else if (wr_en)     chg_q <= wr_val[i];
        end

        assign sticky[i] = chg_q;

        assert_edge_sets_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (live[i] != prev_q[i]) |=> sticky[i]);

        // R7: with no edge and no write, the sticky bit holds
        assert_sticky_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && (live[i] == prev_q[i])) |=> $stable(sticky[i]));
    end
endmodule

// File: rtl/card_pwr_fsm.sv
module card_pwr_fsm
    import card_stchg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr,
    input  logic req_val,
    input  logic pwr_done,
    output logic pwr_dn,
    output logic busy
);
    pwr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_ACTIVE: begin
                if (req_wr && req_val) state_d = PWR_ENTER_DOWN;
            end
            PWR_ENTER_DOWN: begin
                if (req_wr && !req_val) state_d = PWR_EXIT_DOWN;
                else if (pwr_done)      state_d = PWR_DOWN;
            end
            PWR_DOWN: begin
                if (req_wr && !req_val) state_d = PWR_EXIT_DOWN;
            end
            PWR_EXIT_DOWN: begin
                if (req_wr && req_val)  state_d = PWR_ENTER_DOWN;
                else if (pwr_done)      state_d = PWR_ACTIVE;
            end
            default: state_d = PWR_ACTIVE;
        endcase
    end

    always_comb begin
        pwr_dn = (state_q == PWR_ENTER_DOWN) || (state_q == PWR_DOWN);
        busy   = (state_q == PWR_ENTER_DOWN) || (state_q == PWR_EXIT_DOWN);
    end

    assert_change_forces_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && (req_val != pwr_dn)) |=> busy);

    assert_busy_until_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pwr_done) |=> busy);

    assert_idle_stays_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(req_wr && (req_val != pwr_dn))) |=> !busy);
endmodule

// File: rtl/card_stchg_regs.sv
module card_stchg_regs
    import card_stchg_pkg::*;
#(
    parameter int          ADDR_W      = 10,
    parameter int unsigned CFG_OFS     = 'h202,
    parameter int unsigned PIN_OFS     = 'h204,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              ready_raw,
    input  logic              wprot_raw,
    input  logic              irq_req,
    input  logic              irq_dis,
    input  logic              io_mode,
    input  logic              pwr_done,
    output logic              stschg_n,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] CFG_A = CFG_OFS[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] PIN_A = PIN_OFS[ADDR_W-1:0];

    logic sel_cfg, sel_pin;
    logic [NUM_LINES-1:0] raw_vec, live_vec, sticky_vec, pin_wval;
    logic sig_en_q, io8_q, pwr_dn, changed;

    assign sel_cfg = (host_addr == CFG_A);
    assign sel_pin = (host_addr == PIN_A);

    assign raw_vec[LINE_RDY] = ready_raw;
    assign raw_vec[LINE_WP]  = wprot_raw;

    card_line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_vec),
        .sync_out (live_vec)
    );

    assign pin_wval[LINE_RDY] = host_wdata[PIN_RCHG_BIT];
    assign pin_wval[LINE_WP]  = host_wdata[PIN_WCHG_BIT];

    card_change_track #(.WIDTH(NUM_LINES)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .live   (live_vec),
        .wr_en  (host_wr && sel_pin),
        .wr_val (pin_wval),
        .sticky (sticky_vec)
    );

    card_pwr_fsm u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_wr   (host_wr && sel_cfg),
        .req_val  (host_wdata[CFG_PWR_BIT]),
        .pwr_done (pwr_done),
        .pwr_dn   (pwr_dn),
        .busy     (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_en_q <= 1'b0;
            io8_q    <= 1'b0;
        end else if (host_wr && sel_cfg) begin
            sig_en_q <= host_wdata[CFG_SIG_BIT];
            io8_q    <= host_wdata[CFG_IO8_BIT];
        end
    end

    assign changed = |sticky_vec;

    always_comb begin
        host_rdata = 8'h00;
        if (sel_cfg) begin
            host_rdata[CFG_CHG_BIT] = changed;
            host_rdata[CFG_SIG_BIT] = sig_en_q;
            host_rdata[CFG_IO8_BIT] = io8_q;
            host_rdata[CFG_PWR_BIT] = pwr_dn;
            host_rdata[CFG_INT_BIT] = irq_req & ~irq_dis;
        end else if (sel_pin) begin
            host_rdata[PIN_RCHG_BIT] = sticky_vec[LINE_RDY];
            host_rdata[PIN_WCHG_BIT] = sticky_vec[LINE_WP];
            host_rdata[3:2]          = 2'b11;
            host_rdata[1]            = live_vec[LINE_RDY];
            host_rdata[0]            = live_vec[LINE_WP];
        end
    end

    assign stschg_n = ~(io_mode & changed & sig_en_q);

    assert_stschg_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stschg_n |-> (sig_en_q && io_mode && (sticky_vec != '0)));

    assert_stschg_idle_outside_io_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !io_mode |-> stschg_n);
endmodule

// File: tb/card_stchg_regs_tb.sv
module card_stchg_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       ready_raw = 1'b0, wprot_raw = 1'b0;
    logic       irq_req = 1'b0, irq_dis = 1'b0, io_mode = 1'b0, pwr_done = 1'b0;
    logic       stschg_n, busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    card_stchg_regs dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ready_raw(ready_raw), .wprot_raw(wprot_raw), .irq_req(irq_req),
        .irq_dis(irq_dis), .io_mode(io_mode), .pwr_done(pwr_done),
        .stschg_n(stschg_n), .busy(busy)
    );

    // reference model state
    logic m_r1, m_r2, m_rp, m_w1, m_w2, m_wp;
    logic m_rchg, m_wchg, m_sig, m_io8, m_pd, m_busy;

    function automatic logic [7:0] exp_rdata(input logic [9:0] a);
        if (a == 10'h202)
            return {m_rchg | m_wchg, m_sig, m_io8, 2'b00, m_pd, irq_req & ~irq_dis, 1'b0};
        else if (a == 10'h204)
            return {2'b00, m_rchg, m_wchg, 2'b11, m_r2, m_w2};
        return 8'h00;
    endfunction

    function automatic logic exp_stschg();
        return ~(io_mode & (m_rchg | m_wchg) & m_sig);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        {m_r1, m_r2, m_rp, m_w1, m_w2, m_wp} = '0;
        {m_rchg, m_wchg, m_sig, m_io8, m_pd, m_busy} = '0;
    endtask

    // one cycle: drive at negedge, check combinational view, advance model for the posedge
    task automatic step(input logic [9:0] a, input logic w, input logic [7:0] d,
                        input logic rdy, input logic wp, input logic irq,
                        input logic dis, input logic io, input logic dn);
        string tag;
        logic er, ew;
        @(negedge clk);
        host_addr = a; host_wr = w; host_wdata = d;
        ready_raw = rdy; wprot_raw = wp; irq_req = irq; irq_dis = dis;
        io_mode = io; pwr_done = dn;
        #1;
        tag = (a == 10'h202) ? "R2" : (a == 10'h204) ? "R5" : "R1";
        chk(tag, host_rdata, exp_rdata(a));
        chk("R9", {7'd0, stschg_n}, {7'd0, exp_stschg()});
        chk("R10", {7'd0, busy}, {7'd0, m_busy});
        er = m_r2 ^ m_rp;
        ew = m_w2 ^ m_wp;
        if (er) m_rchg = 1'b1; else if (w && a == 10'h204) m_rchg = d[5];
        if (ew) m_wchg = 1'b1; else if (w && a == 10'h204) m_wchg = d[4];
        m_rp = m_r2; m_r2 = m_r1; m_r1 = rdy;
        m_wp = m_w2; m_w2 = m_w1; m_w1 = wp;
        if (w && a == 10'h202) begin
            m_sig = d[6];
            m_io8 = d[5];
            if (d[2] != m_pd) begin
                m_pd = d[2];
                m_busy = 1'b1;
            end else if (m_busy && dn) begin
                m_busy = 1'b0;
            end
        end else if (m_busy && dn) begin
            m_busy = 1'b0;
        end
    endtask

    task automatic idle(input logic [9:0] a);
        step(a, 1'b0, 8'h00, ready_raw, wprot_raw, irq_req, irq_dis, io_mode, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        step(10'h202, 0, 8'h00, 0, 0, 0, 0, 1, 0);
        chk("R11", host_rdata, 8'h00);
        chk("R11", {7'd0, busy}, 8'h00);
        step(10'h204, 0, 8'h00, 0, 0, 0, 0, 1, 0);
        chk("R11", host_rdata, 8'h0C);

        // R3: interrupt pending mirror, gated by disable
        step(10'h202, 0, 8'h00, 0, 0, 1, 0, 0, 0);
        chk("R3", {7'd0, host_rdata[1]}, 8'h01);
        step(10'h202, 0, 8'h00, 0, 0, 1, 1, 1, 0);
        chk("R3", {7'd0, host_rdata[1]}, 8'h00);

        // R5/R6: ready rises; live bit after two edges, sticky after three
        step(10'h204, 0, 8'h00, 1, 0, 0, 0, 1, 0);
        idle(10'h204);
        idle(10'h204);
        chk("R5", {7'd0, host_rdata[1]}, 8'h01);
        chk("R6", {7'd0, host_rdata[5]}, 8'h00);
        idle(10'h204);
        chk("R6", {7'd0, host_rdata[5]}, 8'h01);

        // R8/R9: Changed visible, stschg gated by SigEn then I/O mode
        step(10'h202, 1, 8'h40, 1, 0, 0, 0, 1, 0);
        idle(10'h202);
        chk("R8", {7'd0, host_rdata[7]}, 8'h01);
        chk("R9", {7'd0, stschg_n}, 8'h00);
        step(10'h202, 0, 8'h00, 1, 0, 0, 0, 0, 0);
        chk("R9", {7'd0, stschg_n}, 8'h01);

        // R4: IoByte stored, no effect on other outputs
        step(10'h202, 1, 8'h60, 1, 0, 0, 0, 1, 0);
        idle(10'h202);
        chk("R4", host_rdata, 8'hE0);
        chk("R4", {7'd0, stschg_n}, 8'h00);

        // R7: clear by write, mask bits ignored
        step(10'h204, 1, 8'h03, 1, 0, 0, 0, 1, 0);
        idle(10'h204);
        chk("R7", host_rdata, 8'h0E);
        chk("R9", {7'd0, stschg_n}, 8'h01);

        // R7: edge on ready lands in the same cycle as a clearing write
        step(10'h204, 0, 8'h00, 0, 0, 0, 0, 1, 0);
        idle(10'h204);
        step(10'h204, 1, 8'h00, 0, 0, 0, 0, 1, 0);
        idle(10'h204);
        chk("R7", {7'd0, host_rdata[5]}, 8'h01);

        // R1: unmapped offset reads zero, write there ignored
        step(10'h206, 1, 8'hFF, 0, 0, 0, 0, 1, 0);
        chk("R1", host_rdata, 8'h00);
        idle(10'h202);
        chk("R1", host_rdata, 8'hE0);

        // R10: power-down request, busy until acknowledge
        step(10'h202, 1, 8'h64, 0, 0, 0, 0, 1, 0);
        idle(10'h202);
        chk("R10", {7'd0, busy}, 8'h01);
        step(10'h202, 1, 8'h64, 0, 0, 0, 0, 1, 0);
        idle(10'h202);
        chk("R10", {7'd0, busy}, 8'h01);
        step(10'h202, 0, 8'h00, 0, 0, 0, 0, 1, 1);
        idle(10'h202);
        chk("R10", {7'd0, busy}, 8'h00);
        chk("R10", {7'd0, host_rdata[2]}, 8'h01);
        step(10'h202, 1, 8'h64, 0, 0, 0, 0, 1, 0);
        idle(10'h202);
        chk("R10", {7'd0, busy}, 8'h00);

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [9:0] a;
            logic [1:0] pick;
            pick = 2'($urandom_range(0, 3));
            a = (pick == 2'd0) ? 10'($urandom) : (pick[0] ? 10'h202 : 10'h204);
            step(a, ($urandom_range(0, 3) == 0), 8'($urandom),
                 ($urandom_range(0, 9) == 0) ? ~ready_raw : ready_raw,
                 ($urandom_range(0, 11) == 0) ? ~wprot_raw : wprot_raw,
                 1'($urandom), ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 4) != 0), ($urandom_range(0, 4) == 0));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule